// File: doc/BRIEF.md
# Serial Bit Clock Generator

This block makes the bit clock of a serial audio port. In internal mode it divides the system clock through three stages in series. The first is an optional fixed divide-by-eight. The second is a programmable modulus of 1 to 2^PM_W. The third is an optional divide-by-two. The rate settings are latched only at the terminal count of the chain, so a change never produces a runt period. In external mode the block takes an incoming bit clock instead. That clock passes through a two-flop synchronizer and a rising-edge detector.

The block drives two outputs. `tick` is a one-cycle clock-enable that marks each rising edge of the bit clock, for the shifters that run on the system clock. `bclk_pin` is a registered level for the pad, and it may be inverted. When no run is requested, the pad rests at a programmable idle level. When the clock-off control is set, the divider freezes in place.

A four-state controller picks the mode. The states are S_FROZEN (clock off), S_PARKED (gated idle), S_DIVIDE (internal divider) and S_FOLLOW (external clock). The controller evaluates the same three checks on every cycle, from any state. If `clk_off` is high, the next state is S_FROZEN. Otherwise, if `run_req` is low, the next state is S_PARKED. Otherwise `src_ext` chooses between S_FOLLOW and S_DIVIDE. Reset enters S_PARKED.

Top module: `bclk_gen`

## Requirements
- R1: While `rst_n` is low, `tick` and `bclk_pin` are 0.
- R2: In S_DIVIDE with `half_en`=0, `tick` pulses for one cycle every P system cycles. Here P = (`pm_ratio`+1) × (8 if `range_x8`=1 else 1). `bclk_pin` equals `pin_invert` XOR `tick`.
- R3: Setting `range_x8`=1 multiplies the period P by exactly 8, for every `pm_ratio` value.
- R4: In S_DIVIDE with `half_en`=1, `bclk_pin` (before inversion) is high for P cycles and then low for P cycles. `tick` pulses for one cycle on the sample at which the high phase begins.
- R5: After entering S_DIVIDE from S_PARKED, the first `tick` is seen P+1 cycles after the input change, counted in the bench's negedge samples. In the design this is P cycles after the first edge that samples the run request. The dividers always restart from zero on that entry.
- R6: A change to `pm_ratio`, `range_x8` or `half_en` during S_DIVIDE leaves the period in progress unchanged. The new value applies from the following period on.
- R7: In S_PARKED, `tick` is 0 and `bclk_pin` equals `idle_level`, whatever `pin_invert` is.
- R8: In S_FROZEN, `tick` is 0 and `bclk_pin` holds its value. The divider count is kept, so the tick interval stretches by exactly the number of frozen cycles.
- R9: In S_FOLLOW, `bclk_pin` is `pin_invert` XOR `ext_bclk`, delayed by 3 cycles. `tick` pulses once for each rising edge of `ext_bclk`, 3 cycles after it.
- R10: `clk_off` takes priority over `run_req` and `src_ext`. `run_req` takes priority over `src_ext`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_off | input | 1 | Freeze the divider chain (power saving) |
| run_req | input | 1 | Request a running bit clock; low parks the pin |
| src_ext | input | 1 | 1: follow ext_bclk, 0: divide internally |
| pm_ratio | input | PM_W | Programmable modulus minus one |
| range_x8 | input | 1 | Switch in the fixed divide-by-eight |
| half_en | input | 1 | Switch in the final divide-by-two |
| pin_invert | input | 1 | Invert the running pin level |
| idle_level | input | 1 | Pin level while parked |
| ext_bclk | input | 1 | Incoming bit clock, asynchronous |
| tick | output | 1 | One-cycle enable at each bit clock rising edge |
| bclk_pin | output | 1 | Registered bit clock level for the pad |

## Verification
The bench builds the block with PM_W=4 and FIX_W=3. This keeps every ratio in a full sweep short. All 16 modulus values are run under both range settings, both divide-by-two settings and both pin polarities. For each case the bench checks the first-tick latency, two full periods sample by sample, and the pin shape. Directed runs then cover the timing of a mid-run settings change, freezing across a high phase, gated idle levels, external-clock latency and mode priority.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    typedef enum logic [1:0] {
        S_FROZEN = 2'd0,
        S_PARKED = 2'd1,
        S_DIVIDE = 2'd2,
        S_FOLLOW = 2'd3
    } bclk_state_e;

    // Width needed to hold a divider count up to n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bclk_ext_sync.sv
module bclk_ext_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/bclk_prescaler.sv
module bclk_prescaler #(
    parameter int unsigned PM_W  = 8,
    parameter int unsigned FIX_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clear,
    input  logic [PM_W-1:0] pm_in,
    input  logic            x8_in,
    input  logic            half_in,
    output logic            term,
    output logic [PM_W-1:0] pm_l,
    output logic            x8_l,
    output logic            half_l
);
    logic [PM_W-1:0] pc;
    logic            pre;

    // Fixed pre-divider stage, present only when FIX_W > 0
    generate
        if (FIX_W > 0) begin : g_fix
            localparam logic [FIX_W-1:0] FIX_LAST = '1;
            logic [FIX_W-1:0] fc;
            always_ff @(posedge clk) begin
                if (!rst_n || clear) fc <= '0;
                else if (run)        fc <= x8_l ? fc + 1'b1 : '0;
            end
            assign pre = ~x8_l | (fc == FIX_LAST);
        end else begin : g_nofix
            assign pre = 1'b1;
        end
    endgenerate

    assign term = run & pre & (pc == pm_l);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            pm_l   <= '0;
            x8_l   <= 1'b0;
            half_l <= 1'b0;
        end else if (clear) begin
            pc     <= '0;
            pm_l   <= pm_in;
            x8_l   <= x8_in;
            half_l <= half_in;
        end else if (run && pre) begin
            if (pc == pm_l) begin
                pc     <= '0;
                pm_l   <= pm_in;
                x8_l   <= x8_in;
                half_l <= half_in;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bclk_ctrl_fsm.sv
module bclk_ctrl_fsm
    import bclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_off,
    input  logic        run_req,
    input  logic        src_ext,
    input  logic        term,
    input  logic        half_l,
    input  logic        pin_invert,
    input  logic        idle_level,
    input  logic        ext_lvl,
    input  logic        ext_rise,
    output bclk_state_e state,
    output logic        tick,
    output logic        pin
);
    bclk_state_e state_nx;
    logic        phase;

    always_comb begin
        if (clk_off)       state_nx = S_FROZEN;
        else if (!run_req) state_nx = S_PARKED;
        else if (src_ext)  state_nx = S_FOLLOW;
        else               state_nx = S_DIVIDE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_PARKED;
        else        state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick  <= 1'b0;
            pin   <= 1'b0;
            phase <= 1'b0;
        end else begin
            unique case (state)
                S_FROZEN: begin
                    tick <= 1'b0;
                end
                S_PARKED: begin
                    tick  <= 1'b0;
                    pin   <= idle_level;
                    phase <= 1'b0;
                end
                S_DIVIDE: begin
                    if (term && half_l) begin
                        phase <= ~phase;
                        tick  <= ~phase;
                        pin   <= pin_invert ^ ~phase;
                    end else if (term) begin
                        phase <= 1'b0;
                        tick  <= 1'b1;
                        pin   <= ~pin_invert;
                    end else begin
                        tick <= 1'b0;
                        pin  <= pin_invert ^ (half_l & phase);
                    end
                end
                S_FOLLOW: begin
                    tick  <= ext_rise;
                    pin   <= pin_invert ^ ext_lvl;
                    phase <= 1'b0;
                end
                default: begin
                    tick <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
    import bclk_pkg::*;
#(
    parameter int unsigned PM_W      = 8,
    parameter int unsigned FIX_W     = 3,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_off,
    input  logic            run_req,
    input  logic            src_ext,
    input  logic [PM_W-1:0] pm_ratio,
    input  logic            range_x8,
    input  logic            half_en,
    input  logic            pin_invert,
    input  logic            idle_level,
    input  logic            ext_bclk,
    output logic            tick,
    output logic            bclk_pin
);
    bclk_state_e     state;
    logic            term;
    logic [PM_W-1:0] pm_l;
    logic            x8_l;
    logic            half_l;
    logic            ext_lvl;
    logic            ext_rise;
    logic            div_run;
    logic            div_clear;

    assign div_run   = (state == S_DIVIDE);
    assign div_clear = (state == S_PARKED) || (state == S_FOLLOW);

    bclk_ext_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_bclk),
        .lvl      (ext_lvl),
        .rise     (ext_rise)
    );

    bclk_prescaler #(.PM_W(PM_W), .FIX_W(FIX_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (div_run),
        .clear   (div_clear),
        .pm_in   (pm_ratio),
        .x8_in   (range_x8),
        .half_in (half_en),
        .term    (term),
        .pm_l    (pm_l),
        .x8_l    (x8_l),
        .half_l  (half_l)
    );

    bclk_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_off    (clk_off),
        .run_req    (run_req),
        .src_ext    (src_ext),
        .term       (term),
        .half_l     (half_l),
        .pin_invert (pin_invert),
        .idle_level (idle_level),
        .ext_lvl    (ext_lvl),
        .ext_rise   (ext_rise),
        .state      (state),
        .tick       (tick),
        .pin        (bclk_pin)
    );

endmodule

// File: rtl/bclk_gen_chk.sv
module bclk_gen_chk
    import bclk_pkg::*;
#(
    parameter int unsigned PM_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clk_off,
    input logic            pin_invert,
    input logic            idle_level,
    input logic            tick,
    input logic            bclk_pin,
    input bclk_state_e     state,
    input logic            term,
    input logic [PM_W-1:0] pm_l,
    input logic            half_l,
    input logic            ext_lvl
);
    // R7: parked state gives idle level and no tick
    p_parked_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PARKED) |=> (!tick && bclk_pin == $past(idle_level)));

    // R8: frozen state holds the pin and suppresses ticks
    p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FROZEN) |=> (!tick && $stable(bclk_pin)));

    // R2: without divide-by-two the pin mirrors the tick
    p_pulse_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DIVIDE && !half_l) |=> (bclk_pin == ($past(pin_invert) ^ tick)));

    // R9: follow mode pin tracks the synchronized input
    p_follow_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FOLLOW) |=> (bclk_pin == ($past(pin_invert) ^ $past(ext_lvl))));

    // R10: clock-off wins over every other control
    p_off_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off |=> (state == S_FROZEN));

    // R6: latched modulus only moves at terminal count while dividing
    p_latch_at_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DIVIDE && !term) |=> $stable(pm_l));

endmodule

bind bclk_gen bclk_gen_chk #(.PM_W(PM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_off    (clk_off),
    .pin_invert (pin_invert),
    .idle_level (idle_level),
    .tick       (tick),
    .bclk_pin   (bclk_pin),
    .state      (state),
    .term       (term),
    .pm_l       (pm_l),
    .half_l     (half_l),
    .ext_lvl    (ext_lvl)
);

// File: tb/tb_bclk_gen.sv
module tb_bclk_gen;
    localparam int PM_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clk_off = 1'b0;
    logic            run_req = 1'b0;
    logic            src_ext = 1'b0;
    logic [PM_W-1:0] pm_ratio = '0;
    logic            range_x8 = 1'b0;
    logic            half_en = 1'b0;
    logic            pin_invert = 1'b0;
    logic            idle_level = 1'b0;
    logic            ext_bclk = 1'b0;
    logic            tick;
    logic            bclk_pin;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    bclk_gen #(.PM_W(PM_W), .FIX_W(3), .SYNC_STGS(2)) dut (
        .clk(clk), .rst_n(rst_n), .clk_off(clk_off), .run_req(run_req),
        .src_ext(src_ext), .pm_ratio(pm_ratio), .range_x8(range_x8),
        .half_en(half_en), .pin_invert(pin_invert), .idle_level(idle_level),
        .ext_bclk(ext_bclk), .tick(tick), .bclk_pin(bclk_pin)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 4000);
    endtask

    task automatic park();
        run_req = 1'b0;
        src_ext = 1'b0;
        clk_off = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Sweep one configuration: latency plus two sampled periods
    task automatic sweep_one(input int pm, input bit x8, input bit hf, input bit pol);
        int p, iv, n, bad, act, expv;
        park();
        pm_ratio = pm[PM_W-1:0];
        range_x8 = x8;
        half_en = hf;
        pin_invert = pol;
        @(negedge clk);
        p  = (pm + 1) * (x8 ? 8 : 1);
        iv = hf ? 2 * p : p;
        run_req = 1'b1;
        wait_tick(n);
        chk(n == p + 1, "R5 first tick latency", n, p + 1);
        chk(bclk_pin == (pol ^ 1'b1), hf ? "R4 pin at tick" : "R2 pin at tick",
            int'(bclk_pin), int'(pol ^ 1'b1));
        bad = 0; act = 0; expv = 0;
        for (int k = 1; k <= 2 * iv; k++) begin
            bit et, ep;
            @(negedge clk);
            et = (k % iv) == 0;
            ep = hf ? (pol ^ ((k % (2 * p)) < p)) : (pol ^ et);
            if (bad == 0 && (tick != et || bclk_pin != ep)) begin
                act  = {tick, bclk_pin};
                expv = {et, ep};
                bad  = 1;
            end
        end
        if (hf) chk(bad == 0, "R4 half-rate shape {tick,pin}", act, expv);
        else if (x8) chk(bad == 0, "R3 x8 period {tick,pin}", act, expv);
        else chk(bad == 0, "R2 period {tick,pin}", act, expv);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(tick == 1'b0 && bclk_pin == 1'b0, "R1 reset outputs", {tick, bclk_pin}, 0);
        rst_n = 1'b1;

        // Full sweep
        for (int pm = 0; pm < 16; pm++)
            for (int c = 0; c < 8; c++)
                sweep_one(pm, c[0], c[1], c[2]);

        // R6: settings change applies after the current period
        park();
        pm_ratio = 4'd3; range_x8 = 0; half_en = 0; pin_invert = 0;
        @(negedge clk);
        run_req = 1'b1;
        wait_tick(n);
        pm_ratio = 4'd9;
        wait_tick(n); chk(n == 4, "R6 old modulus period", n, 4);
        wait_tick(n); chk(n == 10, "R6 new modulus period", n, 10);
        range_x8 = 1'b1;
        wait_tick(n); chk(n == 10, "R6 old range period", n, 10);
        wait_tick(n); chk(n == 80, "R6 new range period", n, 80);

        // R7: parked levels ignore inversion; re-entry restarts
        park();
        pin_invert = 1'b1; idle_level = 1'b1;
        repeat (2) @(negedge clk);
        chk(bclk_pin == 1'b1 && tick == 1'b0, "R7 parked high", {tick, bclk_pin}, 1);
        idle_level = 1'b0;
        repeat (2) @(negedge clk);
        chk(bclk_pin == 1'b0 && tick == 1'b0, "R7 parked low", {tick, bclk_pin}, 0);
        pin_invert = 1'b0; pm_ratio = 4'd7; range_x8 = 0; half_en = 0;
        @(negedge clk);
        run_req = 1'b1;
        repeat (5) @(negedge clk);
        run_req = 1'b0;
        repeat (3) @(negedge clk);
        run_req = 1'b1;
        wait_tick(n);
        chk(n == 9, "R7 restart after park", n, 9);

        // R8: freeze across a high phase
        park();
        pm_ratio = 4'd4; range_x8 = 0; half_en = 1; pin_invert = 0;
        @(negedge clk);
        run_req = 1'b1;
        wait_tick(n);
        clk_off = 1'b1;
        begin
            int bad = 0;
            for (int j = 0; j < 7; j++) begin
                @(negedge clk);
                if (bclk_pin != 1'b1 || tick) bad++;
            end
            chk(bad == 0, "R8 frozen pin held high, no tick", bad, 0);
        end
        clk_off = 1'b0;
        wait_tick(n);
        chk(n == 10, "R8 stretched interval remainder", n, 10);

        // R9: external clock following
        park();
        pin_invert = 1'b0; ext_bclk = 1'b0;
        src_ext = 1'b1; run_req = 1'b1;
        repeat (4) @(negedge clk);
        ext_bclk = 1'b1;
        wait_tick(n);
        chk(n == 3, "R9 external tick latency", n, 3);
        chk(bclk_pin == 1'b1, "R9 external pin level", int'(bclk_pin), 1);
        begin
            int cnt = 0;
            for (int j = 0; j < 60; j++) begin
                ext_bclk = ((j % 6) < 3) ? 1'b0 : 1'b1;
                @(negedge clk);
                if (tick) cnt++;
            end
            ext_bclk = 1'b0;
            repeat (5) begin
                @(negedge clk);
                if (tick) cnt++;
            end
            chk(cnt == 10, "R9 one tick per external rise", cnt, 10);
        end
        pin_invert = 1'b1;
        repeat (3) @(negedge clk);
        chk(bclk_pin == 1'b1, "R9 inverted external pin", int'(bclk_pin), 1);

        // R10: clock-off beats run request and source select
        pin_invert = 1'b0; ext_bclk = 1'b1;
        repeat (5) @(negedge clk);
        clk_off = 1'b1; run_req = 1'b0; idle_level = 1'b0;
        begin
            int bad = 0;
            for (int j = 0; j < 20; j++) begin
                ext_bclk = j[1];
                @(negedge clk);
                if (j > 0 && (tick || bclk_pin != 1'b1)) bad++;
            end
            chk(bad == 0, "R10 clock-off priority", bad, 0);
        end
        clk_off = 1'b0; run_req = 1'b0; src_ext = 1'b1;
        repeat (2) @(negedge clk);
        chk(bclk_pin == 1'b0, "R10 park beats external select", int'(bclk_pin), 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule